// File: doc/BRIEF.md
# Clock Control and Wake-Up Unit

This block turns a free-running oscillator into two single-cycle enable streams: a system clock enable and an instruction clock enable. Everything else on the chip advances only on the cycles these enables mark. A 4-bit software register controls the system rate. Its top bit chooses between every oscillator cycle (full rate) and every second oscillator cycle (half rate). The other three bits are plain storage. The instruction enable fires on every third system enable.

Software stops the clocks by pulsing a power-off strobe while the unit runs. The unit then stays asleep until one of two kinds of wake-up event arrives:
- a falling edge on an enabled key-input group;
- an edge into the active level on one of two interrupt pins, where each pin has its own polarity select.

A wake-up reloads the register with its reset value. It also starts an oscillation-settling count. The enables stay off until that count finishes. Reset follows the same settling path.

Top module: `clock_wake_unit`

## Requirements
- R1: While reset is held, sysClkEn and instrClkEn are low and regRdata reads 4'b1000. After reset is released, the first sysClkEn pulse follows the STAB_CYCLES-th rising edge. The unit then runs at half rate.
- R2: A write with regWe stores all four bits of regWdata. regRdata returns them from the next cycle.
- R3: When bit 3 of the register is 0, sysClkEn is high on every cycle. When bit 3 is 1, sysClkEn is high on every second cycle and never on two cycles in a row.
- R4: instrClkEn is high only together with sysClkEn, on every third sysClkEn pulse. The first instrClkEn comes on the third sysClkEn pulse after the clocks start.
- R5: A change of bit 3 while running switches the rate only at a half-rate phase boundary. The new rate holds from the third rising edge after the write cycle. No sysClkEn pulse is shortened or doubled by the switch.
- R6: A powerOff pulse while running stops both enables from the next cycle. They stay low until a wake-up. The register keeps its value while asleep.
- R7: While asleep, a 1-to-0 transition on keyIn[g] with keyEn[g]=1 wakes the unit. The same transition with keyEn[g]=0 has no effect.
- R8: While asleep, irqPin[i] wakes the unit on a rising edge when irqPolHigh[i]=1, and on a falling edge when irqPolHigh[i]=0. An edge of the other direction has no effect.
- R9: After a wake-up is detected, sysClkEn stays low for exactly STAB_CYCLES cycles. The unit then runs with the register reloaded to 4'b1000, so at half rate.
- R10: Key and interrupt edges while running change neither the enables nor the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| oscClk | input | 1 | Oscillator clock; all state is clocked on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 4 | Register write data; bit 3 selects half rate |
| regRdata | output | 4 | Register contents |
| powerOff | input | 1 | One-cycle strobe that stops the clocks |
| keyIn | input | KEY_GROUPS | Key-input group levels, idle high |
| keyEn | input | KEY_GROUPS | Per-group wake-up enable |
| irqPin | input | IRQ_PINS | External interrupt pin levels |
| irqPolHigh | input | IRQ_PINS | Per-pin polarity: 1 rising edge wakes, 0 falling edge wakes |
| sysClkEn | output | 1 | System clock enable pulse |
| instrClkEn | output | 1 | Instruction clock enable pulse |

## Verification
A corrupted rate-select or phase bit shows up directly in the pulse density of sysClkEn. The error is visible within two cycles, because any window of even length must hold either all pulses or exactly half. A divide-by-3 counter that slips shows as a wrong instrClkEn count within any six-pulse window. A stuck sleep or settling state is the slowest fault to surface. It shows as a missing or early first pulse, exactly STAB_CYCLES cycles after the wake edge. A missing register reload shows on regRdata the cycle after the wake.

// File: rtl/cwu_pkg.sv
package cwu_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SLEEP = 2'd2
  } cwuState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic running;
    logic wakeReload;
  } cwuStrobe_t;

  localparam int unsigned MODE_W = 4;
  localparam int unsigned DIV_SEL_BIT = 3;
  localparam logic [MODE_W-1:0] MODE_DEFAULT = 4'b1000;
endpackage

// File: rtl/cwu_ctrl.sv
module cwu_ctrl
  import cwu_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 256,
  parameter int unsigned KEY_GROUPS  = 4,
  parameter int unsigned IRQ_PINS    = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  powerOff,
  input  logic [KEY_GROUPS-1:0] keyIn,
  input  logic [KEY_GROUPS-1:0] keyEn,
  input  logic [IRQ_PINS-1:0]   irqPin,
  input  logic [IRQ_PINS-1:0]   irqPolHigh,
  output cwuStrobe_t            strobe
);
  localparam int unsigned CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

  cwuState_e             state;
  logic [CNT_W-1:0]      stabCnt;
  logic [KEY_GROUPS-1:0] keyPrev;
  logic [IRQ_PINS-1:0]   irqPrev;
  logic [KEY_GROUPS-1:0] keyFall;
  logic [IRQ_PINS-1:0]   irqHit;
  logic                  wakeEvent;

  assign keyFall = keyPrev & ~keyIn & keyEn;

  for (genvar i = 0; i < IRQ_PINS; i++) begin : g_irq
    assign irqHit[i] = irqPolHigh[i] ? (~irqPrev[i] & irqPin[i])
                                     : (irqPrev[i] & ~irqPin[i]);
  end

  assign wakeEvent = (|keyFall) | (|irqHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      stabCnt <= '0;
      keyPrev <= keyIn;
      irqPrev <= irqPin;
    end else begin
      keyPrev <= keyIn;
      irqPrev <= irqPin;
      unique case (state)
        ST_WAIT: begin
          if (stabCnt == CNT_LAST) begin
            state   <= ST_RUN;
            stabCnt <= '0;
          end else begin
            stabCnt <= stabCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (powerOff) state <= ST_SLEEP;
        end
        ST_SLEEP: begin
          if (wakeEvent) begin
            state   <= ST_WAIT;
            stabCnt <= '0;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  assign strobe.running    = (state == ST_RUN);
  assign strobe.wakeReload = (state == ST_SLEEP) && wakeEvent;

  // R6: power-off strobe while running puts the unit to sleep
  p_poweroff_sleeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && powerOff) |=> (state == ST_SLEEP));

  // R6: sleep is left only through a wake event
  p_sleep_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && !wakeEvent) |=> (state == ST_SLEEP));

  // R9: a wake restarts the settling count from zero
  p_wake_restarts_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && wakeEvent) |=> (state == ST_WAIT && stabCnt == '0));

  // R9: the unit runs once the count is complete
  p_count_done_runs_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && stabCnt == CNT_LAST) |=> (state == ST_RUN));

  // R10: wake edges while running do not disturb the running state
  p_run_ignores_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !powerOff) |=> (state == ST_RUN));
endmodule

// File: rtl/cwu_datapath.sv
module cwu_datapath
  import cwu_pkg::*;
#(
  parameter int unsigned INSTR_DIV = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cwuStrobe_t        strobe,
  input  logic              regWe,
  input  logic [MODE_W-1:0] regWdata,
  output logic [MODE_W-1:0] regRdata,
  output logic              sysClkEn,
  output logic              instrClkEn
);
  localparam int unsigned DIV_W = (INSTR_DIV > 2) ? $clog2(INSTR_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INSTR_DIV - 1);

  logic [MODE_W-1:0] modeQ;
  logic              phaseQ;
  logic              div2Active;
  logic [DIV_W-1:0]  div3Cnt;

  assign sysClkEn   = strobe.running & (~div2Active | ~phaseQ);
  assign instrClkEn = sysClkEn & (div3Cnt == DIV_LAST);
  assign regRdata   = modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= MODE_DEFAULT;
      phaseQ     <= 1'b0;
      div2Active <= MODE_DEFAULT[DIV_SEL_BIT];
      div3Cnt    <= '0;
    end else begin
      if (strobe.wakeReload)  modeQ <= MODE_DEFAULT;
      else if (regWe)         modeQ <= regWdata;

      if (!strobe.running) begin
        phaseQ     <= 1'b0;
        div2Active <= modeQ[DIV_SEL_BIT];
        div3Cnt    <= '0;
      end else begin
        phaseQ <= ~phaseQ;
        // rate select is only taken at a half-rate boundary
        if (phaseQ) div2Active <= modeQ[DIV_SEL_BIT];
        if (sysClkEn) div3Cnt <= (div3Cnt == DIV_LAST) ? '0 : div3Cnt + 1'b1;
      end
    end
  end

  // R2: a write lands in the register
  p_write_stores_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !strobe.wakeReload) |=> (regRdata == $past(regWdata)));

  // R5: at half rate no two pulses are adjacent, even across a switch
  p_no_short_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkEn && div2Active) |=> !sysClkEn);

  // R4: instruction pulses are never adjacent
  p_instr_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    instrClkEn |=> !instrClkEn);

  // R9: a wake reloads the register default
  p_reload_default_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wakeReload |=> (regRdata == MODE_DEFAULT));
endmodule

// File: rtl/clock_wake_unit.sv
module clock_wake_unit
  import cwu_pkg::*;
#(
  parameter int unsigned STAB_CYCLES = 256,
  parameter int unsigned KEY_GROUPS  = 4,
  parameter int unsigned IRQ_PINS    = 2,
  parameter int unsigned INSTR_DIV   = 3
) (
  input  logic                  oscClk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [3:0]            regWdata,
  output logic [3:0]            regRdata,
  input  logic                  powerOff,
  input  logic [KEY_GROUPS-1:0] keyIn,
  input  logic [KEY_GROUPS-1:0] keyEn,
  input  logic [IRQ_PINS-1:0]   irqPin,
  input  logic [IRQ_PINS-1:0]   irqPolHigh,
  output logic                  sysClkEn,
  output logic                  instrClkEn
);
  cwuStrobe_t strobe;

  cwu_ctrl #(
    .STAB_CYCLES(STAB_CYCLES),
    .KEY_GROUPS (KEY_GROUPS),
    .IRQ_PINS   (IRQ_PINS)
  ) u_ctrl (
    .clk       (oscClk),
    .rstN      (rstN),
    .powerOff  (powerOff),
    .keyIn     (keyIn),
    .keyEn     (keyEn),
    .irqPin    (irqPin),
    .irqPolHigh(irqPolHigh),
    .strobe    (strobe)
  );

  cwu_datapath #(
    .INSTR_DIV(INSTR_DIV)
  ) u_datapath (
    .clk       (oscClk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .sysClkEn  (sysClkEn),
    .instrClkEn(instrClkEn)
  );
endmodule

// File: tb/clock_wake_unit_bench.sv
module clock_wake_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 32;

  logic       oscClk = 1'b0;
  logic       rstN;
  logic       regWe;
  logic [3:0] regWdata;
  logic [3:0] regRdata;
  logic       powerOff;
  logic [3:0] keyIn;
  logic [3:0] keyEn;
  logic [1:0] irqPin;
  logic [1:0] irqPolHigh;
  logic       sysClkEn;
  logic       instrClkEn;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) oscClk = ~oscClk;

  clock_wake_unit #(.STAB_CYCLES(STAB)) u_clock_wake_unit (
    .oscClk(oscClk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .powerOff(powerOff), .keyIn(keyIn), .keyEn(keyEn),
    .irqPin(irqPin), .irqPolHigh(irqPolHigh), .sysClkEn(sysClkEn),
    .instrClkEn(instrClkEn)
  );

  typedef struct {
    int    n;
    int    sysN;
    int    instrN;
    int    regV;
    string req;
    string regReq;
  } item_t;

  item_t q[$];
  item_t cur;
  bit    busy = 0;
  int    left, sysC, instrC;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver side: push an expected observation window
  task automatic expectWin(input int n, input int sysN, input int instrN,
                           input int regV, input string req, input string regReq);
    item_t it;
    it.n = n; it.sysN = sysN; it.instrN = instrN; it.regV = regV;
    it.req = req; it.regReq = regReq;
    q.push_back(it);
  endtask

  task automatic waitIdle();
    @(negedge oscClk);
    while (q.size() != 0 || busy) @(negedge oscClk);
  endtask

  task automatic writeReg(input logic [3:0] v);
    regWe = 1'b1; regWdata = v;
    @(negedge oscClk);
    regWe = 1'b0;
    @(negedge oscClk);
  endtask

  // monitor: samples just after each rising edge
  always begin
    @(posedge oscClk);
    #1;
    if (!busy && q.size() > 0) begin
      cur = q.pop_front();
      busy = 1; left = cur.n; sysC = 0; instrC = 0;
      if (cur.regV >= 0)
        check(regRdata == cur.regV[3:0], cur.regReq, "regRdata",
              int'(regRdata), cur.regV);
    end
    if (busy) begin
      sysC   += int'(sysClkEn);
      instrC += int'(instrClkEn);
      left--;
      if (left == 0) begin
        check(sysC == cur.sysN, cur.req, "sysClkEn pulses", sysC, cur.sysN);
        if (cur.instrN >= 0)
          check(instrC == cur.instrN, cur.req, "instrClkEn pulses", instrC, cur.instrN);
        busy = 0;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge oscClk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rstN = 1'b0; regWe = 1'b0; regWdata = 4'h0; powerOff = 1'b0;
    keyIn = 4'hF; keyEn = 4'b1101; irqPin = 2'b10; irqPolHigh = 2'b01;
    repeat (3) @(negedge oscClk);

    // R1: reset state, then settling and half-rate start
    expectWin(1, 0, 0, 8, "R1", "R1");
    waitIdle();
    rstN = 1'b1;
    expectWin(STAB - 1, 0, 0, 8, "R1", "R1");
    expectWin(6, 3, 1, -1, "R1", "R1");
    waitIdle();

    // R2 R3 R4 R5: full rate
    writeReg(4'b0111);
    expectWin(6, 6, 2, 7, "R3", "R2");
    waitIdle();
    // half rate
    writeReg(4'b1010);
    expectWin(12, 6, 2, 10, "R5", "R2");
    waitIdle();
    writeReg(4'b0000);
    expectWin(12, 12, 4, 0, "R4", "R2");
    waitIdle();

    // R10: wake edges while running are ignored
    writeReg(4'b0011);
    irqPin[0] = 1'b1; keyIn[0] = 1'b0;
    expectWin(12, 12, 4, 3, "R10", "R10");
    waitIdle();
    irqPin[0] = 1'b0; keyIn[0] = 1'b1;
    irqPin[1] = 1'b0;  // falling edge while running, ignored
    repeat (2) @(negedge oscClk);

    // R6: power off
    powerOff = 1'b1;
    expectWin(20, 0, 0, 3, "R6", "R6");
    @(negedge oscClk);
    powerOff = 1'b0;
    waitIdle();

    // R7: disabled group ignored, enabled group wakes
    keyIn[1] = 1'b0;
    expectWin(40, 0, 0, 3, "R7", "R7");
    waitIdle();
    keyIn[1] = 1'b1;
    @(negedge oscClk);
    keyIn[2] = 1'b0;
    expectWin(STAB, 0, 0, -1, "R9", "R9");
    expectWin(6, 3, 1, 8, "R7", "R9");
    waitIdle();
    keyIn[2] = 1'b1;

    // R8: falling-polarity pin
    writeReg(4'b0001);
    powerOff = 1'b1;
    expectWin(10, 0, 0, 1, "R6", "R6");
    @(negedge oscClk);
    powerOff = 1'b0;
    waitIdle();
    irqPin[1] = 1'b1;  // rising edge, wrong direction
    expectWin(30, 0, 0, 1, "R8", "R8");
    waitIdle();
    irqPin[1] = 1'b0;
    expectWin(STAB, 0, 0, -1, "R9", "R9");
    expectWin(6, 3, 1, 8, "R8", "R9");
    waitIdle();

    // R8: rising-polarity pin
    powerOff = 1'b1;
    expectWin(10, 0, 0, 8, "R6", "R6");
    @(negedge oscClk);
    powerOff = 1'b0;
    waitIdle();
    irqPin[0] = 1'b1;
    expectWin(STAB, 0, 0, -1, "R9", "R9");
    expectWin(6, 3, 1, 8, "R8", "R9");
    waitIdle();

    summary();
  end
endmodule